// File: doc/BRIEF.md
# Lockable Eight-Slot ROM Bank Mapper

This block translates CPU addresses in the lower 2 MB of cartridge space into ROM addresses. The 2 MB window is cut into eight slots of 256 KB. Each slot is filled from one of eight 256 KB ROM banks. Software configures the mapping by writing to three byte-wide control registers placed at low cartridge addresses. Writes to that range would otherwise land on read-only ROM.

A bank index picks the base bank. A mode bit picks one of two layouts. In the first, every slot mirrors the same bank. In the second, the slots walk through consecutive banks and wrap modulo eight. A further bit flags that battery RAM is mapped. A keep-open bit in the second register lets configuration writes through. Once software clears that bit, the configuration is frozen until the next reset. The upper nibble of the index register can be read back through the I/O page. The ROM and RAM arrays sit outside this block.

Top module: `lockable_bank_mapper`

## Requirements
- R1: A write strobe with addr_i[23:16] = 0x00 updates a register chosen by addr_i[11:8]. 0xD selects the RAM register, 0xE selects the mode register and 0xF selects the index register. Each takes wdata_i[7:0].
- R2: A write whose addr_i[23:16] is not 0x00 changes no register. A write whose addr_i[11:8] is not 0xD, 0xE or 0xF also changes no register.
- R3: While mode register bit 7 is 0, every write is ignored. Writing that bit as 0 therefore locks all three registers until reset.
- R4: sram_map_o equals bit 7 of the RAM register.
- R5: The bank index is index register bits [6:4]. rom_addr_o = bank × 0x40000 + addr_i[17:0], a 21-bit address.
- R6: When mode register bit 6 is 1, slot s = addr_i[20:18] maps to bank (index + s) mod 8.
- R7: When mode register bit 6 is 0, every slot maps to the bank index.
- R8: While rd_i is high and addr_i[23:8] = 0xA130, rdata_o = {8'h00, index register & 0xF0}. At all other times rdata_o is 0.
- R9: Reset sets the RAM register to 0x00, the index register to 0x00 and the mode register to 0x80. The block is then unlocked, in mirrored mode, at bank 0, with RAM unmapped.
- R10: wdata_i[15:8] never affects a register, so byte and word writes act the same.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| addr_i | input | 24 | CPU byte address |
| wdata_i | input | 16 | CPU write data |
| wr_i | input | 1 | Write strobe, one access per high cycle |
| rd_i | input | 1 | Read strobe |
| rdata_o | output | 16 | Read-back data from the I/O page |
| rom_addr_o | output | 21 | Translated ROM address |
| sram_map_o | output | 1 | Battery RAM mapped flag |

## Verification
The checker verifies on every cycle that the registers stay frozen while locked or when a write misses the decoder. It also checks that a write to the RAM register shows up on sram_map_o in the next cycle. It checks that read-back data never shows the low nibble or the upper byte, that the offset passes through unchanged, and that the mirrored layout puts the index on the bank field. The bench sweeps every index against every slot in both layouts. It then compares the complete slot-to-bank mapping and the read-back value against arithmetic in the bench. It also covers the lock sequence and recovery through reset, which only a scenario can show.

// File: rtl/mapper_pkg.sv
package mapper_pkg;
  localparam int ADDR_W  = 24;
  localparam int DATA_W  = 16;
  localparam int REG_W   = 8;
  localparam int SLOT_W  = 3;
  localparam int OFS_W   = 18;
  localparam int ROM_W   = SLOT_W + OFS_W;

  localparam logic [3:0]  SEL_CODE_RAM  = 4'hD;
  localparam logic [3:0]  SEL_CODE_MODE = 4'hE;
  localparam logic [3:0]  SEL_CODE_IDX  = 4'hF;
  localparam logic [7:0]  WR_PAGE_HI    = 8'h00;
  localparam logic [15:0] RD_PAGE       = 16'hA130;

  localparam logic [REG_W-1:0] RST_RAM  = 8'h00;
  localparam logic [REG_W-1:0] RST_MODE = 8'h80;
  localparam logic [REG_W-1:0] RST_IDX  = 8'h00;

  localparam int OPEN_BIT   = 7;
  localparam int LINEAR_BIT = 6;
  localparam int SRAM_BIT   = 7;

  typedef enum logic [1:0] {
    SEL_NONE = 2'd0,
    SEL_RAM  = 2'd1,
    SEL_MODE = 2'd2,
    SEL_IDX  = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/mapper_decode.sv
module mapper_decode
  import mapper_pkg::*;
(
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wr_i,
  input  logic              rd_i,
  output reg_sel_e          wr_sel_o,
  output logic              rd_hit_o
);
  logic in_wr_page;

  assign in_wr_page = (addr_i[23:16] == WR_PAGE_HI);

  always_comb begin
    wr_sel_o = SEL_NONE;
    if (wr_i && in_wr_page) begin
      unique case (addr_i[11:8])
        SEL_CODE_RAM:  wr_sel_o = SEL_RAM;
        SEL_CODE_MODE: wr_sel_o = SEL_MODE;
        SEL_CODE_IDX:  wr_sel_o = SEL_IDX;
        default:       wr_sel_o = SEL_NONE;
      endcase
    end
  end

  assign rd_hit_o = rd_i && (addr_i[23:8] == RD_PAGE);
endmodule

// File: rtl/mapper_regs.sv
module mapper_regs
  import mapper_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  reg_sel_e         wr_sel_i,
  input  logic [REG_W-1:0] wbyte_i,
  output logic [REG_W-1:0] ram_q_o,
  output logic [REG_W-1:0] mode_q_o,
  output logic [REG_W-1:0] idx_q_o
);
  logic open_q;
  assign open_q = mode_q_o[OPEN_BIT];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ram_q_o  <= RST_RAM;
      mode_q_o <= RST_MODE;
      idx_q_o  <= RST_IDX;
    end else if (open_q) begin
      case (wr_sel_i)
        SEL_RAM:  ram_q_o  <= wbyte_i;
        SEL_MODE: mode_q_o <= wbyte_i;
        SEL_IDX:  idx_q_o  <= wbyte_i;
        default:  ;
      endcase
    end
  end
endmodule

// File: rtl/mapper_xlate.sv
module mapper_xlate
  import mapper_pkg::*;
#(
  parameter int SW = SLOT_W,
  parameter int OW = OFS_W
) (
  input  logic [SW-1:0]    bank_idx_i,
  input  logic             linear_i,
  input  logic [SW-1:0]    slot_i,
  input  logic [OW-1:0]    ofs_i,
  output logic [SW+OW-1:0] rom_addr_o
);
  localparam int NSLOT = 1 << SW;

  logic [SW-1:0] slot_bank [NSLOT];

  for (genvar g = 0; g < NSLOT; g++) begin : g_slot
    logic [SW-1:0] step;
    assign step         = linear_i ? SW'(g) : '0;
    assign slot_bank[g] = bank_idx_i + step;  // wraps mod NSLOT
  end

  assign rom_addr_o = {slot_bank[slot_i], ofs_i};
endmodule

// File: rtl/lockable_bank_mapper.sv
module lockable_bank_mapper
  import mapper_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              wr_i,
  input  logic              rd_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic [ROM_W-1:0]  rom_addr_o,
  output logic              sram_map_o
);
  reg_sel_e         wr_sel;
  logic             rd_hit;
  logic [REG_W-1:0] ram_q, mode_q, idx_q;

  mapper_decode u_dec (
    .addr_i   (addr_i),
    .wr_i     (wr_i),
    .rd_i     (rd_i),
    .wr_sel_o (wr_sel),
    .rd_hit_o (rd_hit)
  );

  mapper_regs u_regs (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_sel_i (wr_sel),
    .wbyte_i  (wdata_i[REG_W-1:0]),
    .ram_q_o  (ram_q),
    .mode_q_o (mode_q),
    .idx_q_o  (idx_q)
  );

  mapper_xlate u_xlate (
    .bank_idx_i (idx_q[6:4]),
    .linear_i   (mode_q[LINEAR_BIT]),
    .slot_i     (addr_i[20:18]),
    .ofs_i      (addr_i[OFS_W-1:0]),
    .rom_addr_o (rom_addr_o)
  );

  assign sram_map_o = ram_q[SRAM_BIT];
  assign rdata_o    = rd_hit ? {{(DATA_W-REG_W){1'b0}}, idx_q[7:4], 4'h0} : '0;

  logic unused_bits;
  assign unused_bits = ^{wdata_i[DATA_W-1:REG_W], ram_q[6:0], mode_q[5:0], idx_q[3:0]};
endmodule

// File: rtl/lockable_bank_mapper_chk.sv
module lockable_bank_mapper_chk
  import mapper_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic [ADDR_W-1:0] addr_i,
  input logic [DATA_W-1:0] wdata_i,
  input logic              wr_i,
  input logic              rd_i,
  input logic [DATA_W-1:0] rdata_o,
  input logic [ROM_W-1:0]  rom_addr_o,
  input logic              sram_map_o,
  input logic [REG_W-1:0]  ram_q,
  input logic [REG_W-1:0]  mode_q,
  input logic [REG_W-1:0]  idx_q
);
  logic miss_wr;
  assign miss_wr = wr_i && ((addr_i[23:16] != 8'h00) || (addr_i[11:8] < 4'hD));

  // R3
  locked_frozen_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mode_q[OPEN_BIT] |=> $stable({ram_q, mode_q, idx_q}) && !mode_q[OPEN_BIT]);

  // R2
  miss_ignored_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    miss_wr |=> $stable({ram_q, mode_q, idx_q}));

  // R4 R1
  sram_follows_wr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && mode_q[OPEN_BIT] && addr_i[23:16] == 8'h00 && addr_i[11:8] == 4'hD)
      |=> sram_map_o == $past(wdata_i[7]));

  // R8
  rdata_mask_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |-> (rdata_o[3:0] == 4'h0) && (rdata_o[15:8] == 8'h00)
             && (!rd_i -> rdata_o == '0));

  // R5
  offset_pass_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |-> rom_addr_o[OFS_W-1:0] == addr_i[OFS_W-1:0]);

  // R7
  mirror_bank_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mode_q[LINEAR_BIT] |-> rom_addr_o[ROM_W-1:OFS_W] == idx_q[6:4]);
endmodule

bind lockable_bank_mapper lockable_bank_mapper_chk u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .addr_i     (addr_i),
  .wdata_i    (wdata_i),
  .wr_i       (wr_i),
  .rd_i       (rd_i),
  .rdata_o    (rdata_o),
  .rom_addr_o (rom_addr_o),
  .sram_map_o (sram_map_o),
  .ram_q      (ram_q),
  .mode_q     (mode_q),
  .idx_q      (idx_q)
);

// File: tb/lockable_bank_mapper_test.sv
`timescale 1ns/1ps
module lockable_bank_mapper_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [23:0] addr = '0;
  logic [15:0] wdata = '0;
  logic        wr = 1'b0, rd = 1'b0;
  logic [15:0] rdata;
  logic [20:0] rom_addr;
  logic        sram_map;

  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  lockable_bank_mapper uut (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .wdata_i(wdata),
    .wr_i(wr), .rd_i(rd), .rdata_o(rdata), .rom_addr_o(rom_addr), .sram_map_o(sram_map)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr_reg(input logic [23:0] a, input logic [15:0] d);
    @(negedge clk);
    addr = a; wdata = d; wr = 1'b1;
    @(negedge clk);
    wr = 1'b0; addr = '0;
  endtask

  function automatic logic [20:0] exp_rom(input int idx, input bit lin, input int slot,
                                          input logic [17:0] ofs);
    int bank;
    bank = lin ? (idx + slot) % 8 : idx;
    return 21'(bank * 32'h40000 + int'(ofs));
  endfunction

  task automatic check_map(input string req, input int idx, input bit lin);
    for (int s = 0; s < 8; s++) begin
      logic [17:0] ofs;
      ofs = 18'(32'h2A5C3 ^ (s * 32'h1111));
      addr = {3'b000, 3'(s), ofs};
      #1;
      check(req, rom_addr, exp_rom(idx, lin, s, ofs));
    end
    addr = '0;
  endtask

  task automatic check_read(input string req, input logic [7:0] idx_reg);
    addr = 24'hA13000 | 24'(idx_reg); rd = 1'b1;
    #1;
    check(req, rdata, {8'h00, idx_reg & 8'hF0});
    rd = 1'b0; addr = '0;
  endtask

  initial begin
    #(8 * 150000);
    $display("FAIL watchdog: actual timeout expected finish");
    n_chk++; n_bad++;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R9 reset state
    check("R9 sram", sram_map, 1'b0);
    check_map("R9 map", 0, 1'b0);
    check_read("R9 read", 8'h00);
    #1 check("R8 idle rdata", rdata, 16'h0000);

    // R1 R5 R6 R7 R10 sweep
    for (int m = 0; m < 2; m++) begin
      wr_reg(24'h000E01, {8'hFF, 8'h80 | 8'(m << 6)});
      for (int i = 0; i < 8; i++) begin
        logic [7:0] v;
        v = 8'(i << 4) | 8'h0B | (i[0] ? 8'h80 : 8'h00);
        wr_reg(24'h000F00, {8'hA5, v});
        check_map(m ? "R6 linear" : "R7 mirror", i, bit'(m));
        check_read("R8 read", v);
      end
    end

    // R4 R10
    wr_reg(24'h000D01, 16'h7F80);
    check("R4 sram set", sram_map, 1'b1);
    wr_reg(24'h000D01, 16'hFF7F);
    check("R4 R10 sram clear", sram_map, 1'b0);

    // R2 miss writes; index currently 0xF0|0xB with bit7 set for i=7
    wr_reg(24'h000F00, 16'h0050);
    wr_reg(24'h000C00, 16'h0030);
    wr_reg(24'h010F00, 16'h0030);
    wr_reg(24'h000700, 16'h0030);
    wr_reg(24'hA13000, 16'h0030);
    check_read("R2 miss idx", 8'h50);
    check_map("R2 miss map", 5, 1'b1);
    wr_reg(24'h010D00, 16'h0080);
    check("R2 miss sram", sram_map, 1'b0);

    // R8 outside page
    addr = 24'hA13100; rd = 1'b1; #1;
    check("R8 off page", rdata, 16'h0000);
    addr = 24'hA12FFF; #1;
    check("R8 off page low", rdata, 16'h0000);
    rd = 1'b0; addr = '0;

    // R3 lock with linear, index 2
    wr_reg(24'h000F00, 16'h0020);
    wr_reg(24'h000E00, 16'h0040);
    check_map("R3 locked map", 2, 1'b1);
    wr_reg(24'h000F00, 16'h0070);
    wr_reg(24'h000D00, 16'h0080);
    wr_reg(24'h000E00, 16'h0080);
    wr_reg(24'h000F00, 16'h0060);
    check_read("R3 idx frozen", 8'h20);
    check("R3 sram frozen", sram_map, 1'b0);
    check_map("R3 mode frozen", 2, 1'b1);

    // R9 recovery through reset
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
    check_read("R9 idx after reset", 8'h00);
    check_map("R9 map after reset", 0, 1'b0);
    wr_reg(24'h000F00, 16'h0030);
    check_read("R9 R3 unlocked after reset", 8'h30);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule